// File: doc/BRIEF.md
# ALU with Two-Level Operation Decode

This block is the arithmetic-logic unit of a simple single-issue datapath, together with the small decoder that picks its operation. The main controller supplies a 2-bit instruction class. Register-type instructions also supply a 6-bit function field. The decoder turns these two inputs into a 3-bit operation select. The ALU applies that operation to two operands and returns a result and a flag that is set when the result is zero.

Memory-access instructions always need an address sum, and conditional branches always need a difference to test equality. Only register arithmetic looks at the function field. The block is purely combinational and has no clock or reset. The operand width and the adder structure are parameters. The operation select is also brought out so that the decode stage can be observed.

Top module: `alu_ctl_top`

## Requirements
- R1: Operation select 000 gives the bitwise AND of the two operands.
- R2: Operation select 001 gives the bitwise OR of the two operands.
- R3: Operation select 010 gives the sum of the operands modulo 2^32; the carry out is discarded.
- R4: Operation select 110 gives operand A minus operand B modulo 2^32.
- R5: Operation select 111 treats both operands as signed two's-complement values. It gives 1 when A < B and 0 otherwise, zero-extended to 32 bits. The answer must stay correct when the subtraction A-B overflows.
- R6: Instruction class 00 selects operation 010 (add) whatever the function field holds.
- R7: Instruction class 01 selects operation 110 (subtract) whatever the function field holds.
- R8: Instruction class 10 decodes the function field as follows: 0x20 gives add (010), 0x22 gives subtract (110), 0x24 gives AND (000), 0x25 gives OR (001), and 0x2A gives set-less-than (111).
- R9: Under instruction class 10, any function field value not listed in R8 selects add (010). All six bits are compared.
- R10: Instruction class 11 selects add (010) whatever the function field holds.
- R11: The zero output is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class_i | input | 2 | Instruction class from the main controller |
| funct_i | input | 6 | Function field of a register-type instruction |
| opnd_a_i | input | 32 | First operand (A) |
| opnd_b_i | input | 32 | Second operand (B) |
| alu_sel_o | output | 3 | Operation select produced by the decoder |
| result_o | output | 32 | ALU result |
| zero_o | output | 1 | Set when the result is all zeros |

## Verification
The hardest case to reach is a signed compare in which the subtraction A-B overflows. In that case the raw sign bit of the difference gives the wrong answer, and only the overflow correction restores it. Ordinary operand pairs never expose it. The stimulus therefore includes pairs of opposite sign at the extremes of the range: the most negative value against a small positive one, and the most positive value against the most negative. Exhaustive sweeps of the function field under every instruction class show that unlisted codes and near-miss codes, such as 0x05, fall back to add.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;

   // 3-bit operation select; values matter to the decoder and the ALU
   typedef enum logic [2:0] {
      OP_AND = 3'b000,
      OP_OR  = 3'b001,
      OP_ADD = 3'b010,
      OP_SUB = 3'b110,
      OP_SLT = 3'b111
   } alu_sel_e;

   // instruction class driven by the main controller
   localparam logic [1:0] CLS_MEMORY = 2'b00;
   localparam logic [1:0] CLS_BRANCH = 2'b01;
   localparam logic [1:0] CLS_REGOP  = 2'b10;
   localparam logic [1:0] CLS_SPARE  = 2'b11;

   // function field codes decoded under CLS_REGOP
   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
   import alu_ctl_pkg::*;
(
   input  logic [1:0] op_class_i,
   input  logic [5:0] funct_i,
   output alu_sel_e   sel_o
);

   always_comb begin
      unique case (op_class_i)
         CLS_MEMORY: sel_o = OP_ADD;
         CLS_BRANCH: sel_o = OP_SUB;
         CLS_REGOP: begin
            case (funct_i)
               FN_ADD:  sel_o = OP_ADD;
               FN_SUB:  sel_o = OP_SUB;
               FN_AND:  sel_o = OP_AND;
               FN_OR:   sel_o = OP_OR;
               FN_SLT:  sel_o = OP_SLT;
               default: sel_o = OP_ADD;
            endcase
         end
         default: sel_o = OP_ADD;
      endcase

      AST_MEM_CLASS_ADDS : assert (op_class_i != CLS_MEMORY || sel_o == OP_ADD) else $error("memory class not add"); // R6
      AST_BRANCH_CLASS_SUBS : assert (op_class_i != CLS_BRANCH || sel_o == OP_SUB) else $error("branch class not sub"); // R7
      AST_SPARE_CLASS_ADDS : assert (op_class_i != CLS_SPARE || sel_o == OP_ADD) else $error("spare class not add"); // R10
   end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0    // 0: inferred adder, 1: explicit ripple chain
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             ovf_o
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = b_i ^ {WIDTH{sub_i}};

   generate
      if (ADDER_STYLE == 0) begin : g_inferred
         logic carry_out;
         assign {carry_out, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
      end else begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = sub_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]   = a_i[i] ^ b_eff[i] ^ carry[i];
            assign carry[i+1] = (a_i[i] & b_eff[i]) | (carry[i] & (a_i[i] ^ b_eff[i]));
         end
      end
   endgenerate

   // two's-complement overflow: like-signed inputs, differently signed sum
   assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

   always_comb begin
      AST_EQUAL_DIFF_ZERO : assert (!(sub_i && a_i == b_i) || sum_o == '0) else $error("a-a not zero"); // R4
      AST_ADD_ZERO_ID : assert (sub_i || b_i != '0 || sum_o == a_i) else $error("a+0 not a"); // R3
   end

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_ctl_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0
) (
   input  alu_sel_e         sel_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] result_o
);

   localparam int MSB = WIDTH - 1;

   logic             use_sub;
   logic [WIDTH-1:0] arith;
   logic             ovf;
   logic             signed_lt;
   logic [WIDTH-1:0] and_bits;
   logic [WIDTH-1:0] or_bits;

   assign use_sub = (sel_i == OP_SUB) || (sel_i == OP_SLT);

   alu_addsub #(
      .WIDTH      (WIDTH),
      .ADDER_STYLE(ADDER_STYLE)
   ) u_addsub (
      .a_i  (a_i),
      .b_i  (b_i),
      .sub_i(use_sub),
      .sum_o(arith),
      .ovf_o(ovf)
   );

   // sign of the difference, flipped when the subtraction overflowed
   assign signed_lt = arith[MSB] ^ ovf;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_logic_lane
         assign and_bits[i] = a_i[i] & b_i[i];
         assign or_bits[i]  = a_i[i] | b_i[i];
      end
   endgenerate

   always_comb begin
      case (sel_i)
         OP_AND:  result_o = and_bits;
         OP_OR:   result_o = or_bits;
         OP_ADD:  result_o = arith;
         OP_SUB:  result_o = arith;
         OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, signed_lt};
         default: result_o = '0;
      endcase

      AST_AND_SUBSET : assert (sel_i != OP_AND || (result_o & ~a_i) == '0) else $error("and sets bit absent in a"); // R1
      AST_OR_SUPERSET : assert (sel_i != OP_OR || (a_i & ~result_o) == '0) else $error("or drops bit of a"); // R2
      AST_SLT_ZERO_EXT : assert (sel_i != OP_SLT || result_o[WIDTH-1:1] == '0) else $error("slt upper bits set"); // R5
   end

endmodule

// File: rtl/alu_ctl_top.sv
module alu_ctl_top
   import alu_ctl_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic [1:0]       op_class_i,
   input  logic [5:0]       funct_i,
   input  logic [WIDTH-1:0] opnd_a_i,
   input  logic [WIDTH-1:0] opnd_b_i,
   output logic [2:0]       alu_sel_o,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_ctl_top: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("alu_ctl_top: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   alu_sel_e sel;

   alu_op_decoder u_decoder (
      .op_class_i(op_class_i),
      .funct_i   (funct_i),
      .sel_o     (sel)
   );

   alu_core #(
      .WIDTH      (WIDTH),
      .ADDER_STYLE(ADDER_STYLE)
   ) u_core (
      .sel_i   (sel),
      .a_i     (opnd_a_i),
      .b_i     (opnd_b_i),
      .result_o(result_o)
   );

   assign alu_sel_o = sel;
   assign zero_o    = ~|result_o;

   always_comb begin
      AST_BRANCH_EQ_ZERO : assert (!(op_class_i == CLS_BRANCH && opnd_a_i == opnd_b_i) || zero_o) else $error("equal branch operands without zero"); // R11
   end

endmodule

// File: tb/tb_alu_ctl_top.sv
module tb_alu_ctl_top;

   localparam time HALF = 4ns;   // 125 MHz

   typedef struct packed {
      logic [1:0]  cls;
      logic [5:0]  fn;
      logic [31:0] a;
      logic [31:0] b;
      logic [2:0]  sel;
      logic [31:0] res;
      logic        z;
      logic [39:0] tag;
   } vec_t;

   localparam int NVEC = 19;
   localparam vec_t VEC [NVEC] = '{
      '{2'b10, 6'h24, 32'hF0F0_00FF, 32'h0FF0_0F0F, 3'b000, 32'h00F0_000F, 1'b0, "R1+R8"},
      '{2'b10, 6'h24, 32'hAAAA_AAAA, 32'h5555_5555, 3'b000, 32'h0000_0000, 1'b1, "R1+R8"},
      '{2'b10, 6'h25, 32'hF000_0000, 32'h0000_000F, 3'b001, 32'hF000_000F, 1'b0, "R2+R8"},
      '{2'b10, 6'h20, 32'h7FFF_FFFF, 32'h0000_0001, 3'b010, 32'h8000_0000, 1'b0, "R3+R8"},
      '{2'b10, 6'h20, 32'hFFFF_FFFF, 32'h0000_0001, 3'b010, 32'h0000_0000, 1'b1, "R3+R8"},
      '{2'b10, 6'h22, 32'h0000_0005, 32'h0000_0007, 3'b110, 32'hFFFF_FFFE, 1'b0, "R4+R8"},
      '{2'b10, 6'h22, 32'h1234_5678, 32'h1234_5678, 3'b110, 32'h0000_0000, 1'b1, "R4+R8"},
      '{2'b10, 6'h2A, 32'hFFFF_FFFF, 32'h0000_0001, 3'b111, 32'h0000_0001, 1'b0, "R5+R8"},
      '{2'b10, 6'h2A, 32'h0000_0001, 32'hFFFF_FFFF, 3'b111, 32'h0000_0000, 1'b1, "R5+R8"},
      '{2'b10, 6'h2A, 32'h8000_0000, 32'h0000_0001, 3'b111, 32'h0000_0001, 1'b0, "R5"},
      '{2'b10, 6'h2A, 32'h7FFF_FFFF, 32'h8000_0000, 3'b111, 32'h0000_0000, 1'b1, "R5"},
      '{2'b10, 6'h2A, 32'h0000_0003, 32'h0000_0003, 3'b111, 32'h0000_0000, 1'b1, "R5"},
      '{2'b00, 6'h2A, 32'h0000_0100, 32'h0000_0020, 3'b010, 32'h0000_0120, 1'b0, "R6"},
      '{2'b01, 6'h24, 32'h0000_0009, 32'h0000_0009, 3'b110, 32'h0000_0000, 1'b1, "R7"},
      '{2'b01, 6'h20, 32'h0000_0009, 32'h0000_0004, 3'b110, 32'h0000_0005, 1'b0, "R7"},
      '{2'b10, 6'h3F, 32'h0000_0002, 32'h0000_0003, 3'b010, 32'h0000_0005, 1'b0, "R9"},
      '{2'b10, 6'h00, 32'h0000_0010, 32'h0000_000F, 3'b010, 32'h0000_001F, 1'b0, "R9"},
      '{2'b10, 6'h05, 32'h0000_0001, 32'h0000_0001, 3'b010, 32'h0000_0002, 1'b0, "R9"},
      '{2'b11, 6'h22, 32'h0000_0008, 32'h0000_0008, 3'b010, 32'h0000_0010, 1'b0, "R10"}
   };

   logic        clk = 1'b0;
   logic [1:0]  op_class;
   logic [5:0]  funct;
   logic [31:0] opnd_a;
   logic [31:0] opnd_b;
   logic [2:0]  alu_sel;
   logic [31:0] result;
   logic        zero;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   always #HALF clk = ~clk;

   alu_ctl_top dut (
      .op_class_i(op_class),
      .funct_i   (funct),
      .opnd_a_i  (opnd_a),
      .opnd_b_i  (opnd_b),
      .alu_sel_o (alu_sel),
      .result_o  (result),
      .zero_o    (zero)
   );

   task automatic check32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      op_class = c;
      funct    = f;
      opnd_a   = a;
      opnd_b   = b;
      #1ns;
   endtask

   function automatic logic [2:0] exp_sel(input logic [1:0] c, input logic [5:0] f);
      if (c != 2'b10) return (c == 2'b01) ? 3'b110 : 3'b010;
      case (f)
         6'h20: return 3'b010;
         6'h22: return 3'b110;
         6'h24: return 3'b000;
         6'h25: return 3'b001;
         6'h2A: return 3'b111;
         default: return 3'b010;
      endcase
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         summary();
      end
   end

   initial begin
      // quiescent state with all inputs at zero: add of zeros
      apply(2'b00, 6'h00, 32'h0, 32'h0);
      check32("R6", "idle select", {29'h0, alu_sel}, 32'd2);
      check32("R3", "idle result", result, 32'h0);
      check32("R11", "idle zero", {31'h0, zero}, 32'h1);

      // table of vectors
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i].cls, VEC[i].fn, VEC[i].a, VEC[i].b);
         check32(string'(VEC[i].tag), $sformatf("vec %0d select", i), {29'h0, alu_sel}, {29'h0, VEC[i].sel});
         check32(string'(VEC[i].tag), $sformatf("vec %0d result", i), result, VEC[i].res);
         check32("R11", $sformatf("vec %0d zero", i), {31'h0, zero}, {31'h0, VEC[i].z});
      end

      // sweep every function code under every class: R6 R7 R8 R9 R10
      for (int c = 0; c < 4; c++) begin
         for (int f = 0; f < 64; f++) begin
            apply(2'(c), 6'(f), 32'h0000_0006, 32'h0000_0003);
            check32(c == 0 ? "R6" : c == 1 ? "R7" : c == 3 ? "R10" : "R8/R9",
                    $sformatf("class %0d funct %h select", c, f),
                    {29'h0, alu_sel}, {29'h0, exp_sel(2'(c), 6'(f))});
         end
      end

      // signed compare extremes: most negative vs most positive (R5)
      apply(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF);
      check32("R5", "min < max", result, 32'h1);
      apply(2'b10, 6'h2A, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
      check32("R5", "-2 < -1", result, 32'h1);

      // sum overflowing past the top bit discards carry (R3), nonzero result
      apply(2'b00, 6'h00, 32'h8000_0000, 32'h8000_0001);
      check32("R3", "carry dropped", result, 32'h0000_0001);
      check32("R11", "one bit set not zero", {31'h0, zero}, 32'h0);

      summary();
   end

endmodule